// File: doc/BRIEF.md
# Converter Power Sequencer

This block turns a two-bit power-management code into the enable lines that power the internal reference, the converter core and the touch-interrupt path. It also follows each conversion so that, in the power-saving codes, the converter is powered only while a conversion is in flight. A front end that shifts in control words pulses `mode_load` once a whole word is held. It also pulses `conv_start` when a conversion begins, `conv_done` when it completes, and `cs_rise` when chip select is released.

All outputs are registered. A strobe seen at a clock edge shows up on the outputs right after that same edge. The converter therefore comes back to full power with no extra wait cycles. A new power code has no effect until the control word that carries it is complete. A separate output marks the power-down switch state whenever the converter is unpowered.

Top module: `pwr_mode_ctrl`

## Requirements
- R1: After reset the code is PD1=1, PD0=0: `ref_en`=1, `adc_en`=0, `irq_permit`=1, `pd_switch`=1.
- R2: `pd_code[1]` is PD1 and `pd_code[0]` is PD0. A code is taken only at a clock edge where `mode_load` is 1, and the outputs follow it right after that edge. While `mode_load` is 0, changes on `pd_code` leave every output unchanged.
- R3: `ref_en` equals PD1. The reference is on in codes 10 and 11 and off in 00 and 01, and it stays off in 00 and 01 during conversions too.
- R4: In codes 01 and 11 (PD0=1), `adc_en` is held at 1 whatever the conversion strobes do.
- R5: In codes 00 and 10, `adc_en` rises right after the edge that samples `conv_start`.
- R6: In codes 00 and 10, `adc_en` falls right after the edge that samples `conv_done` or `cs_rise`, whichever comes first. The later of the two has no effect. A `conv_start` sampled at the same edge as an end strobe keeps the converter on.
- R7: `irq_permit` is 0 in code 11. In every other code it is 1, except from the edge that samples `conv_start` until the edge that samples the end of that conversion.
- R8: `pd_switch` is always the inverse of `adc_en`.
- R9: A conversion in progress survives a code change. Loading 00 mid-conversion keeps `adc_en` at 1 until the conversion ends. Leaving code 01 after a conversion has ended powers the converter down at once.
- R10: In codes 00 and 10, `adc_en` is 1 on exactly the cycles between the start edge and the end edge of each conversion.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| mode_load | input | 1 | A complete control word is held; take `pd_code` |
| pd_code | input | 2 | Power code, bit 1 = PD1, bit 0 = PD0 |
| conv_start | input | 1 | One-cycle strobe: conversion begins |
| conv_done | input | 1 | One-cycle strobe: conversion complete |
| cs_rise | input | 1 | One-cycle strobe: chip select released |
| ref_en | output | 1 | Internal reference enable |
| adc_en | output | 1 | Converter core power enable |
| irq_permit | output | 1 | Touch interrupt may be raised |
| pd_switch | output | 1 | Converter in power-down (switch state) |

## Verification
The assertions assume that the strobes are single-cycle pulses and that `mode_load` falls on a clock edge boundary. They also assume that an end strobe arriving with no conversion open is harmless, which the design must honour rather than rule out. The end-of-conversion property covers only cycles without a coincident start or code load, because either of those changes the expected state. The bench drives every strobe for exactly one cycle, changing it on the falling edge. It issues end strobes both inside and outside conversions, so the harmless case is actually exercised.

// File: rtl/pwr_pkg.sv
package pwr_pkg;

  localparam int CODE_W = 2;

  typedef enum logic [CODE_W-1:0] {
    PM_ADC_GATED_REF_OFF = 2'b00,
    PM_ADC_ON_REF_OFF    = 2'b01,
    PM_ADC_GATED_REF_ON  = 2'b10,
    PM_ALL_ON            = 2'b11
  } pwr_code_e;

  typedef struct packed {
    logic ref_on;
    logic adc_on;
    logic irq_ok;
    logic pd_sw;
  } pwr_en_t;

  // Map a power code and the conversion-active flag to enable lines.
  function automatic pwr_en_t pwr_decode(input pwr_code_e code, input logic busy);
    pwr_en_t e;
    e.ref_on = 1'b0;
    e.adc_on = busy;
    e.irq_ok = ~busy;
    unique case (code)
      PM_ADC_GATED_REF_OFF: ;
      PM_ADC_ON_REF_OFF:    e.adc_on = 1'b1;
      PM_ADC_GATED_REF_ON:  e.ref_on = 1'b1;
      PM_ALL_ON: begin
        e.ref_on = 1'b1;
        e.adc_on = 1'b1;
        e.irq_ok = 1'b0;
      end
      default: ;
    endcase
    e.pd_sw = ~e.adc_on;
    return e;
  endfunction

endpackage

// File: rtl/pwr_code_reg.sv
module pwr_code_reg
  import pwr_pkg::*;
#(
  parameter pwr_code_e RST_CODE = PM_ADC_GATED_REF_ON
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              load,
  input  logic [CODE_W-1:0] code_in,
  output pwr_code_e         code_nxt,
  output pwr_code_e         code_q
);

  always_comb begin
    code_nxt = code_q;
    if (load) code_nxt = pwr_code_e'(code_in);
  end

  always_ff @(posedge clk) begin
    if (rst) code_q <= RST_CODE;
    else     code_q <= code_nxt;
  end

endmodule

// File: rtl/pwr_conv_track.sv
module pwr_conv_track (
  input  logic clk,
  input  logic rst,
  input  logic start,
  input  logic done,
  input  logic cs_up,
  output logic busy_nxt,
  output logic busy_q
);

  // A start outranks a coincident end so back-to-back conversions stay powered.
  always_comb begin
    busy_nxt = busy_q;
    if (start)              busy_nxt = 1'b1;
    else if (done || cs_up) busy_nxt = 1'b0;
  end

  always_ff @(posedge clk) begin
    if (rst) busy_q <= 1'b0;
    else     busy_q <= busy_nxt;
  end

endmodule

// File: rtl/pwr_out_reg.sv
module pwr_out_reg
  import pwr_pkg::*;
#(
  parameter pwr_code_e RST_CODE = PM_ADC_GATED_REF_ON
) (
  input  logic      clk,
  input  logic      rst,
  input  pwr_code_e code_nxt,
  input  logic      busy_nxt,
  output pwr_en_t   en_q
);

  localparam pwr_en_t RST_EN = pwr_decode(RST_CODE, 1'b0);

  pwr_en_t en_d;

  always_comb en_d = pwr_decode(code_nxt, busy_nxt);

  always_ff @(posedge clk) begin
    if (rst) en_q <= RST_EN;
    else     en_q <= en_d;
  end

endmodule

// File: rtl/pwr_mode_ctrl.sv
module pwr_mode_ctrl
  import pwr_pkg::*;
#(
  parameter pwr_code_e RST_CODE = PM_ADC_GATED_REF_ON
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              mode_load,
  input  logic [CODE_W-1:0] pd_code,
  input  logic              conv_start,
  input  logic              conv_done,
  input  logic              cs_rise,
  output logic              ref_en,
  output logic              adc_en,
  output logic              irq_permit,
  output logic              pd_switch
);

  pwr_code_e code_nxt;
  pwr_code_e mode_q;
  logic      busy_nxt;
  logic      busy_q;
  pwr_en_t   en_q;

  pwr_code_reg #(.RST_CODE(RST_CODE)) u_code (
    .clk      (clk),
    .rst      (rst),
    .load     (mode_load),
    .code_in  (pd_code),
    .code_nxt (code_nxt),
    .code_q   (mode_q)
  );

  pwr_conv_track u_track (
    .clk      (clk),
    .rst      (rst),
    .start    (conv_start),
    .done     (conv_done),
    .cs_up    (cs_rise),
    .busy_nxt (busy_nxt),
    .busy_q   (busy_q)
  );

  pwr_out_reg #(.RST_CODE(RST_CODE)) u_out (
    .clk      (clk),
    .rst      (rst),
    .code_nxt (code_nxt),
    .busy_nxt (busy_nxt),
    .en_q     (en_q)
  );

  assign ref_en     = en_q.ref_on;
  assign adc_en     = en_q.adc_on;
  assign irq_permit = en_q.irq_ok;
  assign pd_switch  = en_q.pd_sw;

endmodule

// File: rtl/pwr_mode_chk.sv
module pwr_mode_chk (
  input logic       clk,
  input logic       rst,
  input logic [1:0] mode_q,
  input logic       mode_load,
  input logic       conv_start,
  input logic       conv_done,
  input logic       cs_rise,
  input logic       ref_en,
  input logic       adc_en,
  input logic       irq_permit,
  input logic       pd_switch
);

  // R8
  pd_switch_inverse_chk: assert property (@(posedge clk) disable iff (rst)
    pd_switch != adc_en);

  // R3
  ref_follows_pd1_chk: assert property (@(posedge clk) disable iff (rst)
    (mode_q == 2'b00 || mode_q == 2'b01) |-> !ref_en);

  // R4
  adc_held_on_chk: assert property (@(posedge clk) disable iff (rst)
    mode_q[0] |-> adc_en);

  // R5
  instant_powerup_chk: assert property (@(posedge clk) disable iff (rst)
    conv_start |=> adc_en);

  // R6
  end_powers_down_chk: assert property (@(posedge clk) disable iff (rst)
    (!conv_start && !mode_load && !mode_q[0] && (conv_done || cs_rise)) |=> !adc_en);

  // R7
  no_irq_all_on_chk: assert property (@(posedge clk) disable iff (rst)
    (mode_q == 2'b11) |-> !irq_permit);

  // R7
  no_irq_while_converting_chk: assert property (@(posedge clk) disable iff (rst)
    (adc_en && !mode_q[0]) |-> !irq_permit);

endmodule

bind pwr_mode_ctrl pwr_mode_chk u_chk (
  .clk        (clk),
  .rst        (rst),
  .mode_q     (mode_q),
  .mode_load  (mode_load),
  .conv_start (conv_start),
  .conv_done  (conv_done),
  .cs_rise    (cs_rise),
  .ref_en     (ref_en),
  .adc_en     (adc_en),
  .irq_permit (irq_permit),
  .pd_switch  (pd_switch)
);

// File: tb/sim_pwr_mode_ctrl.sv
module sim_pwr_mode_ctrl;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       mode_load = 1'b0;
  logic [1:0] pd_code = 2'b00;
  logic       conv_start = 1'b0;
  logic       conv_done = 1'b0;
  logic       cs_rise = 1'b0;
  logic       ref_en, adc_en, irq_permit, pd_switch;

  int checks = 0;
  int fails  = 0;

  always #5 clk = ~clk;

  pwr_mode_ctrl u0 (
    .clk(clk), .rst(rst), .mode_load(mode_load), .pd_code(pd_code),
    .conv_start(conv_start), .conv_done(conv_done), .cs_rise(cs_rise),
    .ref_en(ref_en), .adc_en(adc_en), .irq_permit(irq_permit), .pd_switch(pd_switch)
  );

  // Expected {ref, adc, irq, pd_switch} from the requirement text.
  function automatic logic [3:0] expect_of(input logic [1:0] code, input logic busy);
    logic r, a, i;
    r = code[1];
    a = code[0] | busy;
    i = (code != 2'b11) && !busy;
    return {r, a, i, ~a};
  endfunction

  task automatic chk(input string req, input logic [3:0] exp);
    logic [3:0] act;
    act = {ref_en, adc_en, irq_permit, pd_switch};
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: {ref,adc,irq,pds} actual=%b expected=%b", req, act, exp);
    end
  endtask

  task automatic load_code(input logic [1:0] c);
    @(negedge clk); pd_code = c; mode_load = 1'b1;
    @(negedge clk); mode_load = 1'b0;
  endtask

  task automatic pulse_start();
    @(negedge clk); conv_start = 1'b1;
    @(negedge clk); conv_start = 1'b0;
  endtask

  task automatic pulse_done();
    @(negedge clk); conv_done = 1'b1;
    @(negedge clk); conv_done = 1'b0;
  endtask

  task automatic pulse_cs();
    @(negedge clk); cs_rise = 1'b1;
    @(negedge clk); cs_rise = 1'b0;
  endtask

  task automatic t_reset();
    chk("R1 reset", 4'b1011);
  endtask

  task automatic t_load_ignored();
    @(negedge clk); pd_code = 2'b01;
    @(negedge clk); pd_code = 2'b11;
    @(negedge clk);
    chk("R2 code ignored without load", expect_of(2'b10, 1'b0));
    load_code(2'b00);
    chk("R2 code taken on load", expect_of(2'b00, 1'b0));
  endtask

  task automatic t_gated_done(input logic [1:0] c);
    int on_cnt;
    load_code(c);
    chk("R3 idle gated code", expect_of(c, 1'b0));
    pulse_start();
    chk("R5 powered at start", expect_of(c, 1'b1));
    on_cnt = 0;
    for (int k = 0; k < 7; k++) begin
      @(negedge clk);
      if (adc_en) on_cnt++;
    end
    checks++;
    if (on_cnt != 7) begin
      fails++;
      $display("FAIL R10 active cycles actual=%0d expected=%0d", on_cnt, 7);
    end
    pulse_done();
    chk("R6 off after done", expect_of(c, 1'b0));
    pulse_cs();
    chk("R6 late cs no effect", expect_of(c, 1'b0));
  endtask

  task automatic t_cs_first();
    load_code(2'b00);
    pulse_start();
    pulse_cs();
    chk("R6 off at cs first", expect_of(2'b00, 1'b0));
    pulse_done();
    chk("R6 late done no effect", expect_of(2'b00, 1'b0));
  endtask

  task automatic t_always_on(input logic [1:0] c);
    load_code(c);
    chk("R4 held on", expect_of(c, 1'b0));
    pulse_start();
    chk("R7 irq during conv held-on", expect_of(c, 1'b1));
    pulse_done();
    chk("R4 still on after done", expect_of(c, 1'b0));
    pulse_cs();
    chk("R4 still on after cs", expect_of(c, 1'b0));
  endtask

  task automatic t_coincident();
    load_code(2'b10);
    pulse_start();
    @(negedge clk); conv_start = 1'b1; conv_done = 1'b1;
    @(negedge clk); conv_start = 1'b0; conv_done = 1'b0;
    chk("R6 start beats end", expect_of(2'b10, 1'b1));
    pulse_done();
    chk("R6 end of second conv", expect_of(2'b10, 1'b0));
  endtask

  task automatic t_mode_change();
    load_code(2'b10);
    pulse_start();
    load_code(2'b00);
    chk("R9 conv survives load 00", expect_of(2'b00, 1'b1));
    pulse_done();
    chk("R9 off after done", expect_of(2'b00, 1'b0));
    load_code(2'b01);
    chk("R9 on in 01", expect_of(2'b01, 1'b0));
    load_code(2'b10);
    chk("R9 off leaving 01", expect_of(2'b10, 1'b0));
  endtask

  initial begin
    #1_000_000;
    fails++;
    checks++;
    $display("FAIL watchdog expired actual=timeout expected=finish");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    t_reset();
    t_load_ignored();
    t_gated_done(2'b00);
    t_gated_done(2'b10);
    t_cs_first();
    t_always_on(2'b01);
    t_always_on(2'b11);
    t_coincident();
    t_mode_change();
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

endmodule